// File: doc/BRIEF.md
# Hall-Sensor Tachometer and Rotation-Direction Decoder

This block turns the three Hall-effect sensor lines of a three-phase motor into two things a speed loop needs. The first is a tachometer square wave with an even duty cycle and three full cycles per electrical revolution. The second is a flag that gives the direction of rotation. It also measures the time between tachometer edges in clock cycles. Software or a later arithmetic stage can turn that period into shaft speed. Pulses per mechanical revolution are three times the pole count over two, so a 4-pole motor gives 6. Speed in RPM is the tach frequency times 60, divided by the pulses per revolution.

The Hall lines reach the block already synchronized to `clk`. Only the six codes that hold both a one and a zero are treated as valid. The direction flag moves only when the code steps to a neighbouring sector, so bounce or a missed sector cannot flip it. If no tach edge arrives within a set number of clocks, the motor is taken as stopped: the period output pins at that limit and the measurement is marked not valid.

Top module: `hall_tach_dir`

## Requirements
- R1: While `rst` is high, on each clock edge `tach_out`, `dir_out`, `period_valid` and `period_cnt` are all set to zero.
- R2: The Hall code is {hall_a, hall_b, hall_c}. Once a valid code is accepted, `tach_out` equals the XOR of its three bits, with one clock of latency. So it toggles once per sector and makes three cycles per electrical turn.
- R3: Codes 000 and 111 are invalid. While one is present, `tach_out`, `dir_out`, `period_cnt` and `period_valid` keep their values.
- R4: The clockwise sector order is 101, 100, 110, 010, 011, 001, then back to 101. A one-step move forward in this order sets `dir_out` to 0.
- R5: A one-step move backward in the order of R4 sets `dir_out` to 1.
- R6: A jump of two or three sectors leaves `dir_out` unchanged. The new code becomes the reference for the next step.
- R7: The first valid code after reset becomes the reference and leaves `dir_out` at 0.
- R8: On each tach edge that follows an earlier counted edge, `period_cnt` is set to the number of clocks between the two edges and `period_valid` is set to 1. Both update in the same cycle as `tach_out`.
- R9: The first tach edge after reset or after a stall starts the measurement but does not set `period_valid`.
- R10: If TIMEOUT clocks pass after a tach edge with no new edge, `period_cnt` is set to TIMEOUT and `period_valid` is cleared.
- R11: An interval of exactly TIMEOUT clocks between edges still counts as a valid period of TIMEOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_a | input | 1 | Hall sensor A, synchronized |
| hall_b | input | 1 | Hall sensor B, synchronized |
| hall_c | input | 1 | Hall sensor C, synchronized |
| tach_out | output | 1 | Tachometer square wave, three cycles per electrical turn |
| dir_out | output | 1 | Rotation direction, 0 clockwise and 1 counter-clockwise |
| period_cnt | output | CNT_W | Clocks between the last two tach edges, saturating at TIMEOUT |
| period_valid | output | 1 | `period_cnt` holds a measured period |

## Verification
The assertions check on every cycle that:
- reset clears every output;
- an invalid code freezes the tach and direction outputs;
- each tach toggle matches the parity of the previous cycle's valid code;
- direction changes only after a valid code;
- a valid period stays within 1 to TIMEOUT;
- `period_valid` falls only together with the saturated count.

Only the directed scenarios can show the parts that depend on a sequence of codes: the exact sector order behind each direction, re-basing after a sector jump, the period values after mixed hold times, and the boundary exactly at TIMEOUT.

// File: rtl/hall_tach_pkg.sv
package hall_tach_pkg;

  typedef logic [2:0] hall_code_t;
  typedef logic [2:0] sector_t;

  localparam int unsigned SECTORS = 6;

  // A code is usable only when it holds both a one and a zero.
  function automatic logic code_ok(input hall_code_t c);
    return (c != 3'b000) && (c != 3'b111);
  endfunction

  // Position of a code in the clockwise order.
  function automatic sector_t sector_of(input hall_code_t c);
    sector_t s;
    case (c)
      3'b101:  s = 3'd0;
      3'b100:  s = 3'd1;
      3'b110:  s = 3'd2;
      3'b010:  s = 3'd3;
      3'b011:  s = 3'd4;
      3'b001:  s = 3'd5;
      default: s = 3'd0;
    endcase
    return s;
  endfunction

  function automatic sector_t sector_succ(input sector_t s);
    return (s == sector_t'(SECTORS - 1)) ? 3'd0 : s + 3'd1;
  endfunction

endpackage

// File: rtl/hall_seq_decoder.sv
module hall_seq_decoder
  import hall_tach_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  hall_code_t code_i,
  output logic       load_o,
  output logic       dir_o
);

  hall_code_t ref_q;
  logic       ref_vld_q;
  logic       dir_q;

  logic    legal, differs, step_fwd, step_bwd;
  sector_t s_ref, s_new;

  always_comb begin
    s_ref    = sector_of(ref_q);
    s_new    = sector_of(code_i);
    legal    = code_ok(code_i);
    differs  = !ref_vld_q || (code_i != ref_q);
    step_fwd = ref_vld_q && (sector_succ(s_ref) == s_new);
    step_bwd = ref_vld_q && (sector_succ(s_new) == s_ref);
  end

  assign load_o = legal && differs;
  assign dir_o  = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q     <= '0;
      ref_vld_q <= 1'b0;
      dir_q     <= 1'b0;
    end else if (load_o) begin
      ref_q     <= code_i;
      ref_vld_q <= 1'b1;
      if (step_fwd)      dir_q <= 1'b0;
      else if (step_bwd) dir_q <= 1'b1;
    end
  end

endmodule

// File: rtl/hall_tach_former.sv
module hall_tach_former
  import hall_tach_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  hall_code_t code_i,
  output logic       tach_o,
  output logic       edge_o
);

  logic tach_q;

  assign edge_o = load_i && ((^code_i) != tach_q);
  assign tach_o = tach_q;

  always_ff @(posedge clk) begin
    if (rst)         tach_q <= 1'b0;
    else if (edge_o) tach_q <= ~tach_q;
  end

endmodule

// File: rtl/hall_period_meter.sv
module hall_period_meter #(
  parameter int unsigned TIMEOUT = 50000,
  parameter int unsigned CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  output logic [CNT_W-1:0] period_o,
  output logic             valid_o
);

  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] run_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= '0;
      armed_q  <= 1'b0;
      period_o <= '0;
      valid_o  <= 1'b0;
    end else if (edge_i) begin
      run_q   <= '0;
      armed_q <= 1'b1;
      if (armed_q) begin
        period_o <= run_q + 1'b1;
        valid_o  <= 1'b1;
      end
    end else if (run_q >= LIMIT_M1) begin
      period_o <= LIMIT;
      valid_o  <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

endmodule

// File: rtl/hall_tach_dir.sv
module hall_tach_dir
  import hall_tach_pkg::*;
#(
  parameter  int unsigned TIMEOUT = 50000,
  localparam int unsigned CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hall_a,
  input  logic             hall_b,
  input  logic             hall_c,
  output logic             tach_out,
  output logic             dir_out,
  output logic [CNT_W-1:0] period_cnt,
  output logic             period_valid
);

  hall_code_t code;
  logic       load, tach_edge;

  assign code = {hall_a, hall_b, hall_c};

  hall_seq_decoder u_dec (
    .clk    (clk),
    .rst    (rst),
    .code_i (code),
    .load_o (load),
    .dir_o  (dir_out)
  );

  hall_tach_former u_tach (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .code_i (code),
    .tach_o (tach_out),
    .edge_o (tach_edge)
  );

  hall_period_meter #(
    .TIMEOUT (TIMEOUT),
    .CNT_W   (CNT_W)
  ) u_per (
    .clk      (clk),
    .rst      (rst),
    .edge_i   (tach_edge),
    .period_o (period_cnt),
    .valid_o  (period_valid)
  );

endmodule

// File: rtl/hall_tach_dir_chk.sv
module hall_tach_dir_chk
  import hall_tach_pkg::*;
#(
  parameter  int unsigned TIMEOUT = 50000,
  localparam int unsigned CNT_W   = $clog2(TIMEOUT + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             hall_a,
  input logic             hall_b,
  input logic             hall_c,
  input logic             tach_out,
  input logic             dir_out,
  input logic [CNT_W-1:0] period_cnt,
  input logic             period_valid
);

  hall_code_t code_w;
  assign code_w = {hall_a, hall_b, hall_c};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!tach_out && !dir_out && !period_valid && period_cnt == '0));

  // R3
  bad_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !code_ok(code_w) |=> ($stable(tach_out) && $stable(dir_out)
                          && $stable(period_valid) && $stable(period_cnt)));

  // R2
  tach_parity_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tach_out) |-> (code_ok($past(code_w)) && tach_out == ^$past(code_w)));

  // R4 R5
  dir_source_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_out) |-> code_ok($past(code_w)));

  // R8
  period_range_chk: assert property (@(posedge clk) disable iff (rst)
    period_valid |-> (period_cnt != '0 && period_cnt <= CNT_W'(TIMEOUT)));

  // R8
  valid_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(period_valid) |-> !$stable(tach_out));

  // R10
  stall_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(period_valid) |-> period_cnt == CNT_W'(TIMEOUT));

endmodule

bind hall_tach_dir hall_tach_dir_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .hall_a       (hall_a),
  .hall_b       (hall_b),
  .hall_c       (hall_c),
  .tach_out     (tach_out),
  .dir_out      (dir_out),
  .period_cnt   (period_cnt),
  .period_valid (period_valid)
);

// File: tb/tb_hall_tach_dir.sv
`timescale 1ns/1ps
module tb_hall_tach_dir;

  localparam int unsigned TO = 64;
  localparam int unsigned CW = $clog2(TO + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    hall = 3'b000;
  logic          tach_out, dir_out, period_valid;
  logic [CW-1:0] period_cnt;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  hall_tach_dir #(.TIMEOUT(TO)) dut (
    .clk          (clk),
    .rst          (rst),
    .hall_a       (hall[2]),
    .hall_b       (hall[1]),
    .hall_c       (hall[0]),
    .tach_out     (tach_out),
    .dir_out      (dir_out),
    .period_cnt   (period_cnt),
    .period_valid (period_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] c, input int hold);
    hall = c;
    repeat (hold) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tach", tach_out, 0);
    chk("R1 dir", dir_out, 0);
    chk("R1 valid", period_valid, 0);
    chk("R1 period", period_cnt, 0);
    rst = 1'b0;
  endtask

  task automatic t_first_load;
    put(3'b101, 3);
    chk("R7 dir", dir_out, 0);
    chk("R7 tach", tach_out, 0);
    put(3'b100, 10);
    chk("R9 valid after first edge", period_valid, 0);
    chk("R2 tach 100", tach_out, 1);
  endtask

  task automatic t_clockwise;
    put(3'b110, 10);
    chk("R2 tach 110", tach_out, 0);
    chk("R4 dir", dir_out, 0);
    chk("R8 valid", period_valid, 1);
    chk("R8 period", period_cnt, 10);
    put(3'b010, 10);
    chk("R2 tach 010", tach_out, 1);
    put(3'b011, 7);
    chk("R8 period 10", period_cnt, 10);
    put(3'b001, 7);
    chk("R8 period 7", period_cnt, 7);
    put(3'b101, 7);
    chk("R2 tach 101", tach_out, 0);
    chk("R4 dir wrap", dir_out, 0);
  endtask

  task automatic t_illegal;
    put(3'b111, 5);
    chk("R3 tach 111", tach_out, 0);
    chk("R3 dir 111", dir_out, 0);
    chk("R3 period 111", period_cnt, 7);
    put(3'b000, 5);
    chk("R3 tach 000", tach_out, 0);
    chk("R3 valid 000", period_valid, 1);
  endtask

  task automatic t_counter_cw;
    put(3'b001, 8);
    chk("R5 dir", dir_out, 1);
    chk("R5 tach", tach_out, 1);
    chk("R8 period through invalid codes", period_cnt, 17);
    put(3'b011, 8);
    chk("R5 dir second step", dir_out, 1);
    chk("R8 period 8", period_cnt, 8);
    put(3'b010, 8);
    chk("R2 tach ccw", tach_out, 1);
  endtask

  task automatic t_jump;
    put(3'b101, 8);
    chk("R6 dir held", dir_out, 1);
    chk("R2 tach after jump", tach_out, 0);
    put(3'b100, 8);
    chk("R6 rebased step", dir_out, 0);
    chk("R6 tach", tach_out, 1);
  endtask

  task automatic t_timeout;
    repeat (70) @(negedge clk);
    chk("R10 valid", period_valid, 0);
    chk("R10 period", period_cnt, TO);
    put(3'b110, 1);
    chk("R9 valid after stall", period_valid, 0);
    repeat (TO - 1) @(negedge clk);
    put(3'b010, 1);
    chk("R11 valid", period_valid, 1);
    chk("R11 period", period_cnt, TO);
    repeat (TO) @(negedge clk);
    chk("R10 valid again", period_valid, 0);
    chk("R10 period again", period_cnt, TO);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_first_load();
    t_clockwise();
    t_illegal();
    t_counter_cw();
    t_jump();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-requirements actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule